// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the fetch side of a transmit DMA channel. Software builds a ring of fixed-size descriptors in memory, hands each one to the hardware by setting its ownership flag, and then writes the poll-demand register. The engine walks the ring from its current position. For every descriptor it owns, it reads the buffer the descriptor points at and sends that buffer out one byte at a time on a valid/ready stream, with start-of-frame and end-of-frame markers. When the buffer is done, it writes the descriptor's control word back with ownership cleared and moves to the next descriptor.

A descriptor takes 16 bytes. Its first word carries the control fields and its fourth word (offset 12) carries the buffer address. A frame may span several descriptors. The first-segment flag and the last-segment flag in the control word mark where the frame begins and ends. A ring-end flag sends the walk back to the ring base. The position of that flag can be set by a parameter to bit 30 or bit 15.

The engine stops as soon as it reads a descriptor it does not own. It stays stopped until the next poll demand.

Top module: `txr_ring_engine`

## Requirements
- R1: After reset the engine issues no memory request and holds tx_valid low until a poll demand is written.
- R2: A register write with reg_sel=1 is a poll demand whatever its data. The engine then reads the control word at the current descriptor address, and after that the buffer address at that address plus 12.
- R3: Control word layout: bit 31 is the own flag, bit 29 is first-segment, bit 28 is last-segment, and bits 13:0 are the byte count. A fetched descriptor whose own flag is 0 is not processed, and the engine waits for the next poll demand.
- R4: The engine streams exactly byte-count bytes from a word-aligned buffer, in address order. Within each 32-bit word the least significant byte goes first.
- R5: tx_sof is high only on the first byte of a buffer whose first-segment bit is set. tx_eof is high only on the last byte of a buffer whose last-segment bit is set.
- R6: Once the last byte of a buffer is accepted, the engine writes the control word back to the descriptor address with bit 31 cleared and every other bit unchanged.
- R7: After each write-back the engine moves to the descriptor 16 bytes further on. If the ring-end bit (bit EOR_POS, 30 by default or 15) is set, it returns to the ring base instead. In the default build, bit 15 has no effect on the walk.
- R8: While tx_valid is high and tx_ready is low, tx_data, tx_sof and tx_eof do not change.
- R9: A poll demand that arrives while the engine is busy is remembered. When the engine later meets a descriptor it does not own, it fetches that descriptor again at once.
- R10: A descriptor with a byte count of 0 sends no bytes. It is still written back and the walk still advances.
- R11: A write with reg_sel=0 sets the ring base. When the engine is idle, this write also moves the current position back to that base.
- R12: Memory reads may take any number of cycles to return. The engine keeps one read outstanding and takes its data only when mem_rvalid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = ring base, 1 = poll demand |
| reg_wdata | input | ADDR_W | Register write data |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |

## Verification
The bench targets the points where a ring walker usually goes wrong.

A frame split over three segments of 7, 1 and 53 bytes checks the marker placement. A design that tags every segment would show extra tx_sof or tx_eof pulses.

Three descriptor cases check the walk itself:
- A ring-end descriptor must wrap to the base. An engine that ignores the flag would run off the end and stall.
- A descriptor with bit 15 set must not wrap in the default build. An engine decoding the wrong bit would drop the frame that follows.
- A descriptor with a byte count of 0 must still be handed back. An engine that mishandles it would either hang or send stray bytes.

A poll demand is written while a frame is streaming, and the memory model grants ownership only after the engine has read the next descriptor once. An engine that does not remember that poll would never send the frame. Further runs add stream backpressure and 4-cycle read latency, and a base write while idle must rewind the walk.

// File: rtl/txr_pkg.sv
package txr_pkg;

    // Control word field positions; software and the engine share them.
    localparam int unsigned OWN_POS   = 31;
    localparam int unsigned FIRST_POS = 29;
    localparam int unsigned LAST_POS  = 28;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_D0_REQ,
        ST_D0_WAIT,
        ST_D3_REQ,
        ST_D3_WAIT,
        ST_BUF_REQ,
        ST_BUF_WAIT,
        ST_DRAIN,
        ST_WB
    } eng_st_e;

endpackage

// File: rtl/txr_regs.sv
module txr_regs #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              poll_take_i,
    output logic [ADDR_W-1:0] base_o,
    output logic              rewind_o,
    output logic              poll_pend_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              rew;
        logic              pend;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.rew  = reg_we && !reg_sel;
        if (reg_we && !reg_sel) begin
            r_d.base = reg_wdata;
        end
        // a new demand wins over one being consumed in the same cycle
        r_d.pend = (r_q.pend && !poll_take_i) || (reg_we && reg_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign base_o      = r_q.base;
    assign rewind_o    = r_q.rew;
    assign poll_pend_o = r_q.pend;

    // R2
    poll_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel) |=> poll_pend_o);

endmodule

// File: rtl/txr_serializer.sv
module txr_serializer #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = $clog2(DATA_W / 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              sof_i,
    input  logic              eof_i,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [7:0]        tx_data_o,
    output logic              tx_sof_o,
    output logic              tx_eof_o,
    output logic              last_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic              sof;
        logic              eof;
    } ser_t;

    ser_t s_d, s_q;
    logic fire;

    assign fire = (s_q.cnt != '0) && tx_ready_i;

    always_comb begin
        s_d = s_q;
        if (fire) begin
            s_d.word = s_q.word >> 8;
            s_d.cnt  = s_q.cnt - 1'b1;
            s_d.sof  = 1'b0;
        end
        if (load_i) begin
            s_d.word = word_i;
            s_d.cnt  = cnt_i;
            s_d.sof  = sof_i;
            s_d.eof  = eof_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid_o = (s_q.cnt != '0);
    assign tx_data_o  = s_q.word[7:0];
    assign tx_sof_o   = s_q.sof;
    assign tx_eof_o   = s_q.eof && (s_q.cnt == CNT_W'(1));
    assign last_o     = fire && (s_q.cnt == CNT_W'(1));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=>
            (tx_valid_o && $stable(tx_data_o) && $stable(tx_sof_o) && $stable(tx_eof_o)));

endmodule

// File: rtl/txr_ring_engine.sv
module txr_ring_engine #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SIZE_W  = 14,
    parameter int unsigned EOR_POS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof
);
    import txr_pkg::*;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned BPW        = DATA_W / 8;
    localparam int unsigned CNT_W      = $clog2(BPW) + 1;
    localparam int unsigned DESC_BYTES = 4 * BPW;
    localparam int unsigned BUF_OFS    = 3 * BPW;

    typedef struct packed {
        eng_st_e           st;
        logic [ADDR_W-1:0] cur;
        logic [31:0]       w0;
        logic [ADDR_W-1:0] bptr;
        logic [SIZE_W-1:0] left;
        logic              firstw;
    } eng_t;

    eng_t e_d, e_q;

    logic [ADDR_W-1:0] base;
    logic              rewind, poll_pend, poll_take;
    logic              ser_load, ser_sof, ser_eof, ser_last;
    logic [CNT_W-1:0]  ser_cnt;
    logic              eor_hit;

    txr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .poll_take_i (poll_take),
        .base_o      (base),
        .rewind_o    (rewind),
        .poll_pend_o (poll_pend)
    );

    txr_serializer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ser_load),
        .word_i     (mem_rdata),
        .cnt_i      (ser_cnt),
        .sof_i      (ser_sof),
        .eof_i      (ser_eof),
        .tx_valid_o (tx_valid),
        .tx_ready_i (tx_ready),
        .tx_data_o  (tx_data),
        .tx_sof_o   (tx_sof),
        .tx_eof_o   (tx_eof),
        .last_o     (ser_last)
    );

    // ring-end decode follows the selected layout variant
    generate
        if (EOR_POS == 15) begin : g_eor_low
            assign eor_hit = e_q.w0[15];
        end else begin : g_eor_high
            assign eor_hit = e_q.w0[30];
        end
    endgenerate

    always_comb begin
        e_d       = e_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = e_q.cur;
        mem_wdata = '0;
        poll_take = 1'b0;
        ser_load  = 1'b0;
        ser_cnt   = '0;
        ser_sof   = 1'b0;
        ser_eof   = 1'b0;
        unique case (e_q.st)
            ST_IDLE: begin
                if (rewind) begin
                    e_d.cur = base;
                end else if (poll_pend) begin
                    poll_take = 1'b1;
                    e_d.st    = ST_D0_REQ;
                end
            end
            ST_D0_REQ: begin
                mem_req = 1'b1;
                e_d.st  = ST_D0_WAIT;
            end
            ST_D0_WAIT: begin
                if (mem_rvalid) begin
                    e_d.w0 = mem_rdata;
                    e_d.st = mem_rdata[OWN_POS] ? ST_D3_REQ : ST_IDLE;
                end
            end
            ST_D3_REQ: begin
                mem_req  = 1'b1;
                mem_addr = e_q.cur + ADDR_W'(BUF_OFS);
                e_d.st   = ST_D3_WAIT;
            end
            ST_D3_WAIT: begin
                if (mem_rvalid) begin
                    e_d.bptr   = mem_rdata[ADDR_W-1:0];
                    e_d.left   = e_q.w0[SIZE_W-1:0];
                    e_d.firstw = 1'b1;
                    e_d.st     = (e_q.w0[SIZE_W-1:0] == '0) ? ST_WB : ST_BUF_REQ;
                end
            end
            ST_BUF_REQ: begin
                mem_req  = 1'b1;
                mem_addr = e_q.bptr;
                e_d.st   = ST_BUF_WAIT;
            end
            ST_BUF_WAIT: begin
                if (mem_rvalid) begin
                    ser_load = 1'b1;
                    ser_cnt  = (e_q.left >= SIZE_W'(BPW)) ? CNT_W'(BPW)
                                                          : CNT_W'(e_q.left);
                    ser_sof  = e_q.firstw && e_q.w0[FIRST_POS];
                    ser_eof  = (e_q.left <= SIZE_W'(BPW)) && e_q.w0[LAST_POS];
                    e_d.left   = e_q.left - SIZE_W'(ser_cnt);
                    e_d.bptr   = e_q.bptr + ADDR_W'(BPW);
                    e_d.firstw = 1'b0;
                    e_d.st     = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (ser_last) begin
                    e_d.st = (e_q.left == '0) ? ST_WB : ST_BUF_REQ;
                end
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = e_q.w0 & ~(32'd1 << OWN_POS);
                e_d.cur   = eor_hit ? base : e_q.cur + ADDR_W'(DESC_BYTES);
                e_d.st    = ST_D0_REQ;
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= ST_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    // R6
    eof_then_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_eof) |=> (mem_req && mem_we));

    // R7
    wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (mem_req && !mem_we));

    // R12
    rvalid_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> (e_q.st == ST_D0_WAIT || e_q.st == ST_D3_WAIT ||
                        e_q.st == ST_BUF_WAIT));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_IDLE) |-> (!mem_req && !tx_valid));

endmodule

// File: tb/test_txr_ring_engine.sv
module test_txr_ring_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_sof, tx_eof;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    txr_ring_engine i_txr_ring_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sof(tx_sof), .tx_eof(tx_eof)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [0:2047];
    int          lat = 1;
    int          rd_cnt = 0;
    logic [10:0] rd_idx = '0;
    logic        arm_en = 1'b0;
    logic [10:0] arm_idx = '0;

    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] FST = 32'h2000_0000;
    localparam logic [31:0] LST = 32'h1000_0000;
    localparam logic [31:0] EOR = 32'h4000_0000;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rd_cnt > 0) begin
            rd_cnt <= rd_cnt - 1;
            if (rd_cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[rd_idx];
                if (arm_en && rd_idx == arm_idx) begin
                    mem[arm_idx] = mem[arm_idx] | OWN;
                    arm_en <= 1'b0;
                end
            end
        end
        if (mem_req && !mem_we) begin
            rd_idx <= mem_addr[12:2];
            rd_cnt <= lat;
        end
        if (mem_req && mem_we) mem[mem_addr[12:2]] = mem_wdata;
    end

    // ---------------- stream sink ----------------
    logic [7:0] got_d[$];
    logic       got_s[$];
    logic       got_e[$];
    logic [7:0] exp_d[$];
    logic       exp_s[$];
    logic       exp_e[$];
    logic       bp_en = 1'b0;
    int         bp_cnt = 0;

    always @(negedge clk) begin
        bp_cnt <= bp_cnt + 1;
        tx_ready <= bp_en ? ((bp_cnt % 3) != 0) : 1'b1;
    end

    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            got_d.push_back(tx_data);
            got_s.push_back(tx_sof);
            got_e.push_back(tx_eof);
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'(a * 13 + seed * 29 + 5);
    endfunction

    task automatic clear_q();
        got_d.delete(); got_s.delete(); got_e.delete();
        exp_d.delete(); exp_s.delete(); exp_e.delete();
    endtask

    task automatic add_seg(input int baddr, input int n, input int seed,
                           input bit first, input bit last);
        for (int i = 0; i < n; i++) begin
            int a = baddr + i;
            logic [7:0] b = pat(a, seed);
            mem[a >> 2][8*(a & 3) +: 8] = b;
            exp_d.push_back(b);
            exp_s.push_back(first && i == 0);
            exp_e.push_back(last && i == n - 1);
        end
    endtask

    task automatic put_desc(input int daddr, input logic [31:0] w0, input int baddr);
        mem[daddr >> 2]        = w0;
        mem[(daddr + 12) >> 2] = baddr;
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_done(input int daddr);
        int n = 0;
        while (mem[daddr >> 2][31] && n < 5000) begin
            @(posedge clk);
            n++;
        end
        repeat (40) @(posedge clk);
    endtask

    task automatic cmp_stream(input string req);
        int bad = -1;
        chk(got_d.size() == exp_d.size(), req, "stream length",
            got_d.size(), exp_d.size());
        if (got_d.size() == exp_d.size()) begin
            for (int i = 0; i < exp_d.size(); i++) begin
                if (bad < 0 && (got_d[i] !== exp_d[i] || got_s[i] !== exp_s[i] ||
                                got_e[i] !== exp_e[i])) bad = i;
            end
            if (bad < 0) chk(1'b1, req, "stream", 0, 0);
            else chk(1'b0, req, $sformatf("byte %0d {data,sof,eof}", bad),
                     {got_d[bad], 7'd0, got_s[bad], 7'd0, got_e[bad]},
                     {exp_d[bad], 7'd0, exp_s[bad], 7'd0, exp_e[bad]});
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        bit quiet = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (mem_req || tx_valid) quiet = 1'b0;
        end
        chk(quiet, "R1", "idle after reset {req,valid}", {mem_req, tx_valid}, 0);
    endtask

    task automatic t_single();
        clear_q();
        put_desc('h100, OWN | FST | LST | 32'd60, 'h1000);
        add_seg('h1000, 60, 1, 1, 1);
        reg_write(1'b1, 32'h0);
        wait_done('h100);
        cmp_stream("R2 R3 R4 R5");
        chk(mem['h100 >> 2] == (FST | LST | 32'd60), "R6", "write-back word",
            mem['h100 >> 2], FST | LST | 32'd60);
    endtask

    task automatic t_multi();
        clear_q();
        put_desc('h110, OWN | FST | 32'd7,  'h1100);
        put_desc('h120, OWN | 32'd1,        'h1200);
        put_desc('h130, OWN | LST | 32'd53, 'h1300);
        add_seg('h1100, 7, 2, 1, 0);
        add_seg('h1200, 1, 3, 0, 0);
        add_seg('h1300, 53, 4, 0, 1);
        reg_write(1'b1, 32'hdead_beef);
        wait_done('h130);
        cmp_stream("R5 multi-segment");
        chk(((mem['h110 >> 2] | mem['h120 >> 2] | mem['h130 >> 2]) & OWN) == 0,
            "R6", "all three returned", mem['h130 >> 2], LST | 32'd53);
    endtask

    task automatic t_wrap();
        clear_q();
        put_desc('h140, OWN | EOR | FST | LST | 32'd61, 'h1400);
        put_desc('h100, OWN | FST | LST | 32'd64, 'h1500);
        add_seg('h1400, 61, 5, 1, 1);
        add_seg('h1500, 64, 6, 1, 1);
        reg_write(1'b1, 32'h1);
        wait_done('h100);
        cmp_stream("R7 wrap");
        chk(mem['h140 >> 2] == (EOR | FST | LST | 32'd61), "R7", "ring-end kept",
            mem['h140 >> 2], EOR | FST | LST | 32'd61);
    endtask

    task automatic t_eor15();
        clear_q();
        put_desc('h110, OWN | 32'h8000 | FST | LST | 32'd60, 'h1600);
        put_desc('h120, OWN | FST | LST | 32'd62, 'h1700);
        add_seg('h1600, 60, 7, 1, 1);
        add_seg('h1700, 62, 8, 1, 1);
        reg_write(1'b1, 32'h2);
        wait_done('h120);
        cmp_stream("R7 bit15 ignored");
        chk(mem['h110 >> 2] == (32'h8000 | FST | LST | 32'd60), "R6",
            "bit15 kept", mem['h110 >> 2], 32'h8000 | FST | LST | 32'd60);
    endtask

    task automatic t_backpressure();
        clear_q();
        bp_en = 1'b1;
        put_desc('h130, OWN | FST | LST | 32'd65, 'h1800);
        add_seg('h1800, 65, 9, 1, 1);
        reg_write(1'b1, 32'h3);
        wait_done('h130);
        bp_en = 1'b0;
        cmp_stream("R8 backpressure");
    endtask

    task automatic t_latency();
        clear_q();
        lat = 4;
        put_desc('h140, OWN | EOR | FST | LST | 32'd70, 'h1900);
        add_seg('h1900, 70, 10, 1, 1);
        reg_write(1'b1, 32'h4);
        wait_done('h140);
        lat = 1;
        cmp_stream("R12 latency 4");
    endtask

    task automatic t_zero();
        clear_q();
        put_desc('h100, OWN | FST | LST | 32'd0, 'h1a00);
        put_desc('h110, OWN | FST | LST | 32'd60, 'h1b00);
        add_seg('h1b00, 60, 11, 1, 1);
        reg_write(1'b1, 32'h5);
        wait_done('h110);
        cmp_stream("R10 zero count");
        chk(mem['h100 >> 2] == (FST | LST), "R10", "zero-count returned",
            mem['h100 >> 2], FST | LST);
    endtask

    task automatic t_poll_busy();
        int n = 0;
        clear_q();
        put_desc('h120, OWN | FST | LST | 32'd60, 'h1c00);
        put_desc('h130, FST | LST | 32'd60, 'h1d00);
        add_seg('h1c00, 60, 12, 1, 1);
        add_seg('h1d00, 60, 13, 1, 1);
        arm_idx = 11'('h130 >> 2);
        arm_en  = 1'b1;
        reg_write(1'b1, 32'h6);
        while (got_d.size() == 0 && n < 2000) begin
            @(posedge clk);
            n++;
        end
        reg_write(1'b1, 32'h7);
        wait_done('h120);
        wait_done('h130);
        arm_en = 1'b0;
        cmp_stream("R9 remembered poll");
    endtask

    task automatic t_rewind();
        clear_q();
        put_desc('h100, OWN | FST | LST | 32'd60, 'h1e00);
        add_seg('h1e00, 60, 14, 1, 1);
        reg_write(1'b0, 32'h100);
        reg_write(1'b1, 32'h8);
        wait_done('h100);
        cmp_stream("R11 rewind");
    endtask

    task automatic run_all();
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        reg_write(1'b0, 32'h100);
        t_single();
        t_multi();
        t_wrap();
        t_eor15();
        t_backpressure();
        t_latency();
        t_zero();
        t_poll_busy();
        t_rewind();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog: actual=expired expected=finished");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule